// File: doc/BRIEF.md
# Bus Debug Trigger Controller

This block watches the address and direction of every CPU bus access and compares it against two reference addresses, A and B. Software sets up an 8-bit control word and arms the block. While armed, qualifying accesses are recorded into an 8-entry trace buffer. A match on either comparator is the trigger. When a run completes, the block disarms itself and can send the CPU a one-cycle break request, marked as tag-type or force-type.

A mode input picks how a run behaves. In end-trace mode the buffer keeps the most recent accesses, and the trigger access closes the run. In begin-trace mode recording starts at the trigger access, and the run closes once the buffer is full. Hold the mode steady for the length of a run. A secure input stops software from enabling the block. After a run, the recorded addresses are read out oldest first.

Top module: `dbg_trig_ctl`

## Requirements
- R1: After reset the control word reads 0x00, the armed flag is 0, no break request is active and the trace buffer is empty.
- R2: A control write loads the word, with bits 7..0 being enable, arm, tag select, break enable, A direction select, A direction qualify, B direction select and B direction qualify. The read port returns the stored word. While the secure input is 1, a write leaves enable at 0.
- R3: A control write with arm 1 sets arm and the armed flag only if enable ends up 1. A write that starts a new run (the block was not already armed) clears the trace buffer and forgets any earlier trigger.
- R4: A control write with arm 0 or enable 0 stops a run at once and clears arm and the armed flag. Later accesses are neither recorded nor cause a break.
- R5: A comparator hits on a valid access whose address equals its reference. When its qualify bit is 1, the access must also be a read (select 1) or a write (select 0). When its qualify bit is 0, direction is ignored. A hit on A or B is a trigger. Reference addresses are loaded through their own write ports.
- R6: In end-trace mode every valid access while armed is recorded, and the oldest entry is dropped when 8 are held. The trigger access is recorded and completes the run.
- R7: In begin-trace mode, accesses before the trigger are not recorded. The trigger access and the ones after it are recorded, and the run completes when the 8th entry is stored.
- R8: Completion clears arm and the armed flag on the same clock edge that records the final access. If break enable was 1, the break request is high for exactly the following cycle.
- R9: With break enable 0 no break request is produced, although recording and completion still happen. The break type output is 1 (tag) only during a request made with tag select 1. It is 0 otherwise (force type, or no request).
- R10: While not armed, bus accesses are ignored. A bus access in the same cycle as a control write is not recorded and does not trigger.
- R11: The trace read port shows the oldest entry. A pop removes it when the block is not armed, the buffer is not empty and no control write is present. Pops at other times are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| secure_i | input | 1 | Security state; 1 blocks setting enable |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control word write data |
| ctl_rdata_o | output | 8 | Stored control word |
| armf_o | output | 1 | Armed status flag |
| cmpa_we_i | input | 1 | Comparator A reference write strobe |
| cmpa_wdata_i | input | 16 | Comparator A reference address |
| cmpb_we_i | input | 1 | Comparator B reference write strobe |
| cmpb_wdata_i | input | 16 | Comparator B reference address |
| end_mode_i | input | 1 | 1 = end-trace mode, 0 = begin-trace mode |
| bus_valid_i | input | 1 | A bus access is present this cycle |
| bus_addr_i | input | 16 | Bus access address |
| bus_rd_i | input | 1 | 1 = read access, 0 = write access |
| brk_req_o | output | 1 | One-cycle CPU break request |
| brk_tag_o | output | 1 | Break type, 1 = tag, 0 = force |
| trc_pop_i | input | 1 | Remove the oldest trace entry |
| trc_empty_o | output | 1 | Trace buffer holds no entry |
| trc_count_o | output | 4 | Number of trace entries held |
| trc_data_o | output | 16 | Oldest trace entry |

## Verification
Direction qualification is tried with reads and writes to both reference addresses under each qualify/select setting, which shows whether each comparator uses its own bits. An end-trace run with more than eight accesses before the trigger shows oldest-first dropping. A begin-trace run with non-matching accesses ahead of the trigger shows that recording starts at the trigger and that completion follows the eighth entry. Runs with break enable off, tag off and on, manual stops by either bit, and bus accesses placed in control-write cycles or in idle time tell apart the break gating, the stop paths and the ignore rules.

// File: rtl/dbgt_pkg.sv
package dbgt_pkg;

  // Control word, bit 7 first; software decodes these positions.
  typedef struct packed {
    logic en;      // bit 7
    logic arm;     // bit 6
    logic tag;     // bit 5
    logic brk_en;  // bit 4
    logic rws_a;   // bit 3 : 1 read, 0 write
    logic rwq_a;   // bit 2 : direction qualifies comparator A
    logic rws_b;   // bit 1
    logic rwq_b;   // bit 0
  } dbgt_ctl_t;

  localparam int NCMP = 2;

endpackage

// File: rtl/dbgt_cmp.sv
module dbgt_cmp #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_we_i,
  input  logic [AW-1:0] ref_wdata_i,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          qual_en_i,
  input  logic          rd_sel_i,
  output logic          hit_o
);

  logic [AW-1:0] ref_q;
  logic [AW-1:0] ref_d;
  logic          dir_ok;

  always_comb begin
    ref_d = ref_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
    end else if (ref_we_i) begin
      ref_q <= ref_d;
    end
  end

  always_comb begin
    dir_ok = ~qual_en_i | (rd_i == rd_sel_i);
    hit_o  = valid_i & (addr_i == ref_q) & dir_ok;
  end

endmodule

// File: rtl/dbgt_ctl_reg.sv
module dbgt_ctl_reg
  import dbgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       secure_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       done_i,
  output dbgt_ctl_t  ctl_o,
  output logic       armf_o,
  output logic       armed_o,
  output logic       arm_start_o
);

  dbgt_ctl_t ctl_q, ctl_d;
  logic      armf_q, armf_d;
  logic      upd_en;
  logic      armed_now;

  assign armed_now = ctl_q.en & ctl_q.arm;

  always_comb begin
    ctl_d       = ctl_q;
    armf_d      = armf_q;
    arm_start_o = 1'b0;
    if (we_i) begin
      ctl_d       = dbgt_ctl_t'(wdata_i);
      ctl_d.en    = wdata_i[7] & ~secure_i;
      ctl_d.arm   = wdata_i[6] & ctl_d.en;
      armf_d      = ctl_d.arm;
      arm_start_o = ctl_d.arm & ~armed_now;
    end else if (done_i) begin
      ctl_d.arm = 1'b0;
      armf_d    = 1'b0;
    end
  end

  assign upd_en = we_i | done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      armf_q <= 1'b0;
    end else if (upd_en) begin
      ctl_q  <= ctl_d;
      armf_q <= armf_d;
    end
  end

  assign ctl_o   = ctl_q;
  assign armf_o  = armf_q;
  assign armed_o = armed_now;

endmodule

// File: rtl/dbgt_trace_buf.sv
module dbgt_trace_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic [DW-1:0] head_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, empty, do_push, do_pop, drop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i & ~clr_i;
  assign do_pop  = pop_i & ~empty & ~do_push & ~clr_i;
  assign drop    = do_push & full;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) begin
        wr_d = ptr_inc(wr_q);
      end
      if (do_pop || drop) begin
        rd_d = ptr_inc(rd_q);
      end
      if (do_push && !full) begin
        cnt_d = cnt_q + CW'(1);
      end else if (do_pop) begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wr_q] <= push_data_i;
    end
  end

  assign count_o = cnt_q;
  assign empty_o = empty;
  assign head_o  = mem_q[rd_q];

endmodule

// File: rtl/dbgt_seq.sv
module dbgt_seq #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed_i,
  input  logic          arm_start_i,
  input  logic          ctl_we_i,
  input  logic          end_mode_i,
  input  logic          bus_valid_i,
  input  logic          hit_i,
  input  logic [CW-1:0] trc_count_i,
  input  logic          brk_en_i,
  input  logic          tag_i,
  output logic          push_o,
  output logic          done_o,
  output logic          brk_req_o,
  output logic          brk_tag_o
);

  logic cap_ok;
  logic trig_q, trig_d;
  logic brk_req_q, brk_req_d;
  logic brk_tag_q, brk_tag_d;
  logic last_slot;

  assign cap_ok    = armed_i & bus_valid_i & ~ctl_we_i;
  assign last_slot = (int'(trc_count_i) >= DEPTH - 1);

  always_comb begin
    if (end_mode_i) begin
      push_o = cap_ok;
      done_o = cap_ok & hit_i;
    end else begin
      push_o = cap_ok & (trig_q | hit_i);
      done_o = push_o & last_slot;
    end
  end

  always_comb begin
    trig_d = trig_q;
    if (arm_start_i) begin
      trig_d = 1'b0;
    end else if (cap_ok && hit_i) begin
      trig_d = 1'b1;
    end
    brk_req_d = done_o & brk_en_i;
    brk_tag_d = done_o & brk_en_i & tag_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q    <= 1'b0;
      brk_req_q <= 1'b0;
      brk_tag_q <= 1'b0;
    end else begin
      trig_q    <= trig_d;
      brk_req_q <= brk_req_d;
      brk_tag_q <= brk_tag_d;
    end
  end

  assign brk_req_o = brk_req_q;
  assign brk_tag_o = brk_tag_q;

endmodule

// File: rtl/dbg_trig_ctl.sv
module dbg_trig_ctl
  import dbgt_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         secure_i,
  input  logic                         ctl_we_i,
  input  logic [7:0]                   ctl_wdata_i,
  output logic [7:0]                   ctl_rdata_o,
  output logic                         armf_o,
  input  logic                         cmpa_we_i,
  input  logic [AW-1:0]                cmpa_wdata_i,
  input  logic                         cmpb_we_i,
  input  logic [AW-1:0]                cmpb_wdata_i,
  input  logic                         end_mode_i,
  input  logic                         bus_valid_i,
  input  logic [AW-1:0]                bus_addr_i,
  input  logic                         bus_rd_i,
  output logic                         brk_req_o,
  output logic                         brk_tag_o,
  input  logic                         trc_pop_i,
  output logic                         trc_empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   trc_count_o,
  output logic [AW-1:0]                trc_data_o
);

  localparam int CW = $clog2(DEPTH + 1);

  dbgt_ctl_t       ctl;
  logic            armed, arm_start, done, push, pop, hit;
  logic [NCMP-1:0] cmp_we, cmp_qual, cmp_sel, cmp_hit;
  logic [AW-1:0]   cmp_wdata [NCMP];
  logic [CW-1:0]   cnt;

  dbgt_ctl_reg u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .secure_i    (secure_i),
    .we_i        (ctl_we_i),
    .wdata_i     (ctl_wdata_i),
    .done_i      (done),
    .ctl_o       (ctl),
    .armf_o      (armf_o),
    .armed_o     (armed),
    .arm_start_o (arm_start)
  );

  assign cmp_we       = {cmpb_we_i, cmpa_we_i};
  assign cmp_qual     = {ctl.rwq_b, ctl.rwq_a};
  assign cmp_sel      = {ctl.rws_b, ctl.rws_a};
  assign cmp_wdata[0] = cmpa_wdata_i;
  assign cmp_wdata[1] = cmpb_wdata_i;

  for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
    dbgt_cmp #(.AW(AW)) u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_we_i    (cmp_we[gi]),
      .ref_wdata_i (cmp_wdata[gi]),
      .valid_i     (bus_valid_i),
      .addr_i      (bus_addr_i),
      .rd_i        (bus_rd_i),
      .qual_en_i   (cmp_qual[gi]),
      .rd_sel_i    (cmp_sel[gi]),
      .hit_o       (cmp_hit[gi])
    );
  end

  assign hit = |cmp_hit;

  dbgt_seq #(.DEPTH(DEPTH)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .armed_i     (armed),
    .arm_start_i (arm_start),
    .ctl_we_i    (ctl_we_i),
    .end_mode_i  (end_mode_i),
    .bus_valid_i (bus_valid_i),
    .hit_i       (hit),
    .trc_count_i (cnt),
    .brk_en_i    (ctl.brk_en),
    .tag_i       (ctl.tag),
    .push_o      (push),
    .done_o      (done),
    .brk_req_o   (brk_req_o),
    .brk_tag_o   (brk_tag_o)
  );

  assign pop = trc_pop_i & ~armed & ~ctl_we_i;

  dbgt_trace_buf #(.DEPTH(DEPTH), .DW(AW)) u_trc (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (arm_start),
    .push_i      (push),
    .push_data_i (bus_addr_i),
    .pop_i       (pop),
    .count_o     (cnt),
    .empty_o     (trc_empty_o),
    .head_o      (trc_data_o)
  );

  assign ctl_rdata_o = ctl;
  assign trc_count_o = cnt;

endmodule

// File: rtl/dbgt_chk.sv
module dbgt_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       secure_i,
  input logic                       ctl_we_i,
  input logic [7:0]                 ctl_wdata_i,
  input logic [7:0]                 ctl_rdata_o,
  input logic                       armf_o,
  input logic                       brk_req_o,
  input logic                       brk_tag_o,
  input logic                       trc_pop_i,
  input logic                       trc_empty_o,
  input logic [$clog2(DEPTH+1)-1:0] trc_count_o
);

  AST_SECURE_HOLDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i && secure_i |=> !ctl_rdata_o[7]); // R2
  AST_LOW_BITS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i |=> ctl_rdata_o[5:0] == $past(ctl_wdata_i[5:0])); // R2
  AST_ARM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata_o[6] |-> ctl_rdata_o[7]); // R3
  AST_ARM_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i && ctl_wdata_i[7] && ctl_wdata_i[6] && !secure_i |=> armf_o && ctl_rdata_o[6]); // R3
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i && !(ctl_wdata_i[7] && ctl_wdata_i[6]) |=> !armf_o && !ctl_rdata_o[6]); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(trc_count_o) <= DEPTH); // R6
  AST_BRK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req_o |=> !brk_req_o); // R8
  AST_BRK_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req_o |-> !ctl_rdata_o[6] && !armf_o); // R8
  AST_BRK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req_o |-> $past(ctl_rdata_o[4])); // R9
  AST_TAG_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    brk_tag_o |-> brk_req_o); // R9
  AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata_o[6] && !trc_pop_i && !ctl_we_i |=> $stable(trc_count_o)); // R10
  AST_POP_TAKES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata_o[6] && trc_pop_i && !ctl_we_i && !trc_empty_o
    |=> int'(trc_count_o) == int'($past(trc_count_o)) - 1); // R11

endmodule

bind dbg_trig_ctl dbgt_chk #(.DEPTH(DEPTH)) u_dbgt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .secure_i    (secure_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .ctl_rdata_o (ctl_rdata_o),
  .armf_o      (armf_o),
  .brk_req_o   (brk_req_o),
  .brk_tag_o   (brk_tag_o),
  .trc_pop_i   (trc_pop_i),
  .trc_empty_o (trc_empty_o),
  .trc_count_o (trc_count_o)
);

// File: tb/test_dbg_trig_ctl.sv
module test_dbg_trig_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DEPTH = 8;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst_n, secure, ctl_we, armf, cmpa_we, cmpb_we, end_mode;
  logic          bus_valid, bus_rd, brk_req, brk_tag, trc_pop, trc_empty;
  logic [7:0]    ctl_wdata, ctl_rdata;
  logic [AW-1:0] cmpa_wdata, cmpb_wdata, bus_addr, trc_data;
  logic [3:0]    trc_count;

  dbg_trig_ctl #(.AW(AW), .DEPTH(DEPTH)) i_dbg_trig_ctl (
    .clk(clk), .rst_n(rst_n), .secure_i(secure),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata), .armf_o(armf),
    .cmpa_we_i(cmpa_we), .cmpa_wdata_i(cmpa_wdata), .cmpb_we_i(cmpb_we), .cmpb_wdata_i(cmpb_wdata),
    .end_mode_i(end_mode), .bus_valid_i(bus_valid), .bus_addr_i(bus_addr), .bus_rd_i(bus_rd),
    .brk_req_o(brk_req), .brk_tag_o(brk_tag),
    .trc_pop_i(trc_pop), .trc_empty_o(trc_empty), .trc_count_o(trc_count), .trc_data_o(trc_data)
  );

  // Behavioural reference model
  logic [7:0]    m_ctl;
  logic          m_armf, m_brk, m_tag, m_trig;
  logic [AW-1:0] m_ra, m_rb;
  logic [AW-1:0] m_q[$];
  int            n_cmp = 0;
  int            n_bad = 0;
  string         cur_req = "R1";
  bit            finished = 0;

  function automatic logic m_hit(input logic [AW-1:0] r, input logic qual, input logic sel);
    return bus_valid && (bus_addr == r) && (!qual || (bus_rd == sel));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 8'h00; m_armf = 0; m_brk = 0; m_tag = 0; m_trig = 0;
      m_ra = '0; m_rb = '0;
      m_q.delete();
    end else begin
      logic armed, done, push, hit, en, ar;
      armed = m_ctl[7] && m_ctl[6];
      done = 0; push = 0;
      if (ctl_we) begin
        en = ctl_wdata[7] && !secure;
        ar = ctl_wdata[6] && en;
        if (ar && !armed) begin
          m_q.delete();
          m_trig = 0;
        end
        m_ctl = {en, ar, ctl_wdata[5:0]};
        m_armf = ar;
      end else if (armed && bus_valid) begin
        hit = m_hit(m_ra, m_ctl[2], m_ctl[3]) || m_hit(m_rb, m_ctl[0], m_ctl[1]);
        if (end_mode) begin
          push = 1;
          done = hit;
        end else begin
          if (hit) m_trig = 1;
          push = m_trig;
        end
        if (push) begin
          if (m_q.size() == DEPTH) void'(m_q.pop_front());
          m_q.push_back(bus_addr);
          if (!end_mode && m_q.size() == DEPTH) done = 1;
        end
        if (done) begin
          m_ctl[6] = 0;
          m_armf = 0;
        end
      end else if (!armed && trc_pop && m_q.size() > 0) begin
        void'(m_q.pop_front());
      end
      m_brk = done && m_ctl[4];
      m_tag = done && m_ctl[4] && m_ctl[5];
      if (cmpa_we) m_ra = cmpa_wdata;
      if (cmpb_we) m_rb = cmpb_wdata;
    end
  end

  task automatic chk(input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("ctl_rdata", 32'(ctl_rdata), 32'(m_ctl));
      chk("armf", 32'(armf), 32'(m_armf));
      chk("brk_req", 32'(brk_req), 32'(m_brk));
      chk("brk_tag", 32'(brk_tag), 32'(m_tag));
      chk("trc_count", 32'(trc_count), 32'(m_q.size()));
      chk("trc_empty", 32'(trc_empty), 32'(m_q.size() == 0));
      if (m_q.size() > 0) chk("trc_data", 32'(trc_data), 32'(m_q[0]));
    end
  end

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    summary();
  end

  // Stimulus helpers: called at a falling edge, return at the next one.
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_ctl(input logic [7:0] v);
    ctl_we = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 0;
  endtask
  task automatic acc(input logic [AW-1:0] a, input logic rd);
    bus_valid = 1; bus_addr = a; bus_rd = rd;
    @(negedge clk);
    bus_valid = 0;
  endtask
  task automatic pop(input int n);
    trc_pop = 1;
    repeat (n) @(negedge clk);
    trc_pop = 0;
  endtask
  task automatic set_refs(input logic [AW-1:0] a, input logic [AW-1:0] b);
    cmpa_we = 1; cmpa_wdata = a; cmpb_we = 1; cmpb_wdata = b;
    @(negedge clk);
    cmpa_we = 0; cmpb_we = 0;
  endtask

  initial begin
    rst_n = 0; secure = 0; ctl_we = 0; ctl_wdata = '0; cmpa_we = 0; cmpb_we = 0;
    cmpa_wdata = '0; cmpb_wdata = '0; end_mode = 1; bus_valid = 0; bus_addr = '0;
    bus_rd = 0; trc_pop = 0;
    cur_req = "R1";
    idle(3);
    rst_n = 1;
    idle(2);

    cur_req = "R2";
    wr_ctl(8'h3F);
    wr_ctl(8'h2A);
    secure = 1;
    wr_ctl(8'hFF);
    secure = 0;
    wr_ctl(8'h00);

    cur_req = "R3";
    set_refs(16'h1234, 16'h5678);
    wr_ctl(8'h40);
    wr_ctl(8'hC0);
    idle(2);
    wr_ctl(8'hC0);
    wr_ctl(8'h00);

    cur_req = "R5";
    end_mode = 1;
    wr_ctl(8'hDF);
    acc(16'h1234, 0);
    acc(16'h5678, 0);
    acc(16'h5678, 1);
    idle(2);
    wr_ctl(8'hD1);
    acc(16'h5678, 1);
    acc(16'h1234, 1);
    idle(2);
    cmpa_we = 1; cmpa_wdata = 16'hABCD;
    @(negedge clk);
    cmpa_we = 0;
    wr_ctl(8'hD0);
    acc(16'h1234, 0);
    acc(16'hABCD, 0);
    idle(2);

    cur_req = "R6";
    wr_ctl(8'hD0);
    for (int i = 0; i < 11; i++) acc(16'h2000 + 16'(i), 1'(i % 2));
    acc(16'h5678, 0);
    idle(2);

    cur_req = "R11";
    pop(2);
    wr_ctl(8'hC0);
    acc(16'h3001, 1);
    acc(16'h3002, 0);
    acc(16'h3003, 1);
    pop(3);
    wr_ctl(8'h00);
    pop(5);
    idle(1);

    cur_req = "R7 R8";
    end_mode = 0;
    wr_ctl(8'hD0);
    acc(16'h4001, 1);
    acc(16'h4002, 0);
    acc(16'h4003, 1);
    acc(16'h1234, 1);
    for (int i = 0; i < 7; i++) acc(16'h4100 + 16'(i), 1'(i % 2));
    acc(16'h4200, 0);
    idle(2);

    cur_req = "R9";
    end_mode = 1;
    wr_ctl(8'hE0);
    acc(16'h4444, 0);
    acc(16'h1234, 0);
    idle(2);
    wr_ctl(8'hF0);
    acc(16'h5678, 1);
    idle(2);
    end_mode = 0;
    wr_ctl(8'hE0);
    acc(16'h5678, 0);
    for (int i = 0; i < 7; i++) acc(16'h4500 + 16'(i), 1);
    idle(2);

    cur_req = "R4";
    end_mode = 1;
    wr_ctl(8'hD0);
    acc(16'h2222, 1);
    wr_ctl(8'h90);
    acc(16'h1234, 1);
    acc(16'h5678, 0);
    idle(1);
    wr_ctl(8'hD0);
    acc(16'h2223, 0);
    wr_ctl(8'h50);
    acc(16'h1234, 0);
    idle(2);

    cur_req = "R10";
    acc(16'h1234, 1);
    acc(16'h5678, 0);
    wr_ctl(8'h90);
    acc(16'h1234, 1);
    ctl_we = 1; ctl_wdata = 8'hD0; bus_valid = 1; bus_addr = 16'h1234; bus_rd = 1;
    @(negedge clk);
    ctl_we = 0;
    ctl_wdata = 8'hD0; bus_valid = 1; bus_addr = 16'h6000;
    @(negedge clk);
    bus_valid = 0;
    acc(16'h1234, 1);
    idle(3);
    pop(10);
    idle(2);

    summary();
  end

endmodule